// File: doc/BRIEF.md
# Open-Drain Boundary Scan Register

This block is a boundary-scan data register for a chip whose bidirectional pins are open-drain. It is built as a row of cells, and each cell has one of four kinds. A plain input cell samples its pin. An open-drain combo cell also samples its pin, and it uses the same scan bit as both its output value and its own driver enable. A 0 in that bit pulls the pad low. A 1 releases the pad, and an external pull-up then reads it as a weak high. An input-only combo cell sits on a bidirectional pad but only samples it. A fixed cell has no pin and samples a constant that is set per position.

A test access port controller, which is outside this block, supplies the test clock, an asynchronous test reset, and three strobes: capture, shift and update. It also supplies an external-test mode flag. Data moves through the chain from `tdi` toward `tdo`. Cell 0 sits next to `tdo`, and the highest-numbered cell receives `tdi`.

The update stage is a hold register that loads on the falling test-clock edge. It drives the open-drain pads only while the external-test flag is high. At all other times the pads follow the pull-low requests from the core.

Top module: `bscan_chain`

## Requirements
- R1: A low `trst_n` presets every shift bit and every hold bit to 1, without waiting for a clock edge. While external test is on, this leaves every pad released (`pad_pull_low` all 0). A read of the chain straight after reset returns all ones.
- R2: When `shift_en` is high and `capture_en` is low, each rising `tck` moves every bit one place toward `tdo`. `tdi` enters cell NUM_CELLS-1, and `tdo` always shows cell 0.
- R3: `CELL_MAP` gives each cell a 2-bit kind in bits [2i+1:2i]: 0 is input, 1 is open-drain combo, 2 is fixed, 3 is input-only combo. The default repeats the kinds 0,1,1,2,3 for cell index mod 5. When capture runs, cells of kind 0, 1 and 3 load their `pin_in` bit.
- R4: When capture runs, cells of kind 2 load their `FIX_VAL` bit. With the defaults, that bit is 1 at cells 3 and 13 and 0 at cells 8 and 18.
- R5: An update copies the whole chain into the hold stage on the falling `tck` edge while `update_en` is high. Pads follow the new hold value from that edge onward.
- R6: While `extest_en` is high, an open-drain cell whose hold bit is 0 asserts its `pad_pull_low` bit. If its hold bit is 1, the pad is released.
- R7: Cells of kind 0, 2 and 3 never assert `pad_pull_low`, in either mode.
- R8: While `extest_en` is low, the `pad_pull_low` bit of each open-drain cell follows its `core_pull_low` bit, whatever the hold stage contains.
- R9: While `update_en` is low, shifting and capturing leave the hold stage unchanged, and so leave the pads unchanged.
- R10: When `capture_en` and `shift_en` are both high on a rising edge, the capture takes effect and the shift does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial data into the highest cell |
| capture_en | input | 1 | Parallel capture strobe (rising edge) |
| shift_en | input | 1 | Shift strobe (rising edge) |
| update_en | input | 1 | Update strobe (falling edge) |
| extest_en | input | 1 | Hold stage drives the pads when high |
| pin_in | input | NUM_CELLS | Pad levels as seen by the cells |
| core_pull_low | input | NUM_CELLS | Pull-low requests from the core for the open-drain pads |
| tdo | output | 1 | Serial data out of cell 0 |
| pad_pull_low | output | NUM_CELLS | Pull-low enables to the pads (1 means drive low) |

## Verification
The assertions assume that the strobes, `tdi`, `extest_en` and `trst_n` change only away from both clock edges. Under that assumption, the values sampled at a rising edge are the ones the chain acted on, and the values sampled at a falling edge are the ones the hold stage acted on. The assertions also assume that the reset is released while no update is pending. The bench changes every input 2 ns after a rising edge, which is well clear of the falling edge at mid-period. It reads `tdo` and the pads 2 ns after the falling edge. It raises `update_en` only for single cycles after reset has been released.

// File: rtl/bscan_chain_pkg.sv
package bscan_chain_pkg;

    // Kind of each scan cell, two bits per cell in the cell map.
    typedef enum logic [1:0] {
        CELL_PIN_IN  = 2'd0,   // samples a pin, never drives
        CELL_OPEN_DR = 2'd1,   // samples and drives low; 1 releases
        CELL_FIXED   = 2'd2,   // no pin, samples a constant
        CELL_OBS_BI  = 2'd3    // bidirectional pad, sample only
    } cell_kind_e;

endpackage

// File: rtl/bscan_cell_decode.sv
module bscan_cell_decode
    import bscan_chain_pkg::*;
#(
    parameter int                        NUM_CELLS = 20,
    parameter logic [2*NUM_CELLS-1:0]    CELL_MAP  = {4{10'b11_10_01_01_00}},
    parameter logic [NUM_CELLS-1:0]      FIX_VAL   = 20'h02008
) (
    input  logic [NUM_CELLS-1:0] pin_in,
    output logic [NUM_CELLS-1:0] cap_val,
    output logic [NUM_CELLS-1:0] od_mask,
    output logic [NUM_CELLS-1:0] fix_mask
);

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
        localparam cell_kind_e KIND    = cell_kind_e'(CELL_MAP[2*i +: 2]);
        localparam logic       IS_FIX  = (KIND == CELL_FIXED);
        localparam logic       IS_OD   = (KIND == CELL_OPEN_DR);

        // Fixed cells sample their constant; all others sample the pad.
        assign cap_val[i]  = IS_FIX ? FIX_VAL[i] : pin_in[i];
        assign od_mask[i]  = IS_OD;
        assign fix_mask[i] = IS_FIX;
    end

endmodule

// File: rtl/bscan_shift_stage.sv
module bscan_shift_stage #(
    parameter int NUM_CELLS = 20
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 tdi,
    input  logic                 capture_en,
    input  logic                 shift_en,
    input  logic [NUM_CELLS-1:0] cap_val,
    output logic [NUM_CELLS-1:0] chain_q
);

    typedef struct packed {
        logic [NUM_CELLS-1:0] bits;
    } shift_st_t;

    shift_st_t st_d, st_q;

    // Capture wins over shift when both strobes are high.
    always_comb begin
        st_d = st_q;
        if (capture_en) begin
            st_d.bits = cap_val;
        end else if (shift_en) begin
            st_d.bits = {tdi, st_q.bits[NUM_CELLS-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign chain_q = st_q.bits;

endmodule

// File: rtl/bscan_hold_stage.sv
module bscan_hold_stage #(
    parameter int NUM_CELLS = 20
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 update_en,
    input  logic [NUM_CELLS-1:0] chain_q,
    output logic [NUM_CELLS-1:0] hold_q
);

    typedef struct packed {
        logic [NUM_CELLS-1:0] bits;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (update_en) begin
            st_d.bits = chain_q;
        end
    end

    // Falling edge, so the pads never see a half-shifted value.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_q = st_q.bits;

endmodule

// File: rtl/bscan_pad_mux.sv
module bscan_pad_mux #(
    parameter int NUM_CELLS = 20
) (
    input  logic                 extest_en,
    input  logic [NUM_CELLS-1:0] od_mask,
    input  logic [NUM_CELLS-1:0] hold_q,
    input  logic [NUM_CELLS-1:0] core_pull_low,
    output logic [NUM_CELLS-1:0] pad_pull_low
);

    // A hold bit of 1 doubles as the driver disable: released pad.
    always_comb begin
        if (extest_en) begin
            pad_pull_low = od_mask & ~hold_q;
        end else begin
            pad_pull_low = od_mask & core_pull_low;
        end
    end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_chain_pkg::*;
#(
    parameter int                        NUM_CELLS = 20,
    parameter logic [2*NUM_CELLS-1:0]    CELL_MAP  = {4{10'b11_10_01_01_00}},
    parameter logic [NUM_CELLS-1:0]      FIX_VAL   = 20'h02008
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 tdi,
    input  logic                 capture_en,
    input  logic                 shift_en,
    input  logic                 update_en,
    input  logic                 extest_en,
    input  logic [NUM_CELLS-1:0] pin_in,
    input  logic [NUM_CELLS-1:0] core_pull_low,
    output logic                 tdo,
    output logic [NUM_CELLS-1:0] pad_pull_low
);

    logic [NUM_CELLS-1:0] cap_val;
    logic [NUM_CELLS-1:0] od_mask;
    logic [NUM_CELLS-1:0] fix_mask;
    logic [NUM_CELLS-1:0] chain_q;
    logic [NUM_CELLS-1:0] hold_q;

    bscan_cell_decode #(
        .NUM_CELLS (NUM_CELLS),
        .CELL_MAP  (CELL_MAP),
        .FIX_VAL   (FIX_VAL)
    ) u_decode (
        .pin_in   (pin_in),
        .cap_val  (cap_val),
        .od_mask  (od_mask),
        .fix_mask (fix_mask)
    );

    bscan_shift_stage #(
        .NUM_CELLS (NUM_CELLS)
    ) u_shift (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .cap_val    (cap_val),
        .chain_q    (chain_q)
    );

    bscan_hold_stage #(
        .NUM_CELLS (NUM_CELLS)
    ) u_hold (
        .tck       (tck),
        .trst_n    (trst_n),
        .update_en (update_en),
        .chain_q   (chain_q),
        .hold_q    (hold_q)
    );

    bscan_pad_mux #(
        .NUM_CELLS (NUM_CELLS)
    ) u_pad (
        .extest_en     (extest_en),
        .od_mask       (od_mask),
        .hold_q        (hold_q),
        .core_pull_low (core_pull_low),
        .pad_pull_low  (pad_pull_low)
    );

    assign tdo = chain_q[0];

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
    parameter int                     NUM_CELLS = 20,
    parameter logic [NUM_CELLS-1:0]   FIX_VAL   = 20'h02008
) (
    input logic                 tck,
    input logic                 trst_n,
    input logic                 tdi,
    input logic                 capture_en,
    input logic                 shift_en,
    input logic                 update_en,
    input logic                 extest_en,
    input logic [NUM_CELLS-1:0] pin_in,
    input logic [NUM_CELLS-1:0] chain_q,
    input logic [NUM_CELLS-1:0] hold_q,
    input logic [NUM_CELLS-1:0] od_mask,
    input logic [NUM_CELLS-1:0] fix_mask,
    input logic [NUM_CELLS-1:0] pad_pull_low
);

    // R2: one step toward tdo per rising edge
    a_r2_shift_step: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_en && !capture_en) |=>
            (chain_q == {$past(tdi), $past(chain_q[NUM_CELLS-1:1])}));

    // R3 and R10: pin-backed cells hold the sampled pad after capture
    a_r3_pin_capture: assert property (@(posedge tck) disable iff (!trst_n)
        capture_en |=> ((chain_q & ~fix_mask) == ($past(pin_in) & ~fix_mask)));

    // R4: fixed cells hold their constant after capture
    a_r4_fixed_capture: assert property (@(posedge tck) disable iff (!trst_n)
        capture_en |=> ((chain_q & fix_mask) == (FIX_VAL & fix_mask)));

    // R9: hold stage is quiet without an update strobe
    a_r9_hold_quiet: assert property (@(negedge tck) disable iff (!trst_n)
        !update_en |=> $stable(hold_q));

    // R5 and R6: after an update under external test, pads show the inverted chain
    a_r6_extest_drive: assert property (@(negedge tck) disable iff (!trst_n)
        (update_en && extest_en) |=>
            (!extest_en || (pad_pull_low == (od_mask & ~$past(chain_q)))));

    // R1: reset presets both stages
    a_r1_reset_preset: assert property (@(posedge tck)
        !trst_n |-> ((&hold_q) && (&chain_q)));

endmodule

bind bscan_chain bscan_chain_chk #(
    .NUM_CELLS (NUM_CELLS),
    .FIX_VAL   (FIX_VAL)
) u_chk (
    .tck          (tck),
    .trst_n       (trst_n),
    .tdi          (tdi),
    .capture_en   (capture_en),
    .shift_en     (shift_en),
    .update_en    (update_en),
    .extest_en    (extest_en),
    .pin_in       (pin_in),
    .chain_q      (chain_q),
    .hold_q       (hold_q),
    .od_mask      (od_mask),
    .fix_mask     (fix_mask),
    .pad_pull_low (pad_pull_low)
);

// File: tb/bscan_chain_bench.sv
module bscan_chain_bench;

    localparam int N          = 20;
    localparam int TCK_PERIOD = 10;

    logic         tck;
    logic         trst_n;
    logic         tdi;
    logic         capture_en;
    logic         shift_en;
    logic         update_en;
    logic         extest_en;
    logic [N-1:0] pin_in;
    logic [N-1:0] core_pull_low;
    logic         tdo;
    logic [N-1:0] pad_pull_low;

    bscan_chain u_bscan_chain (
        .tck           (tck),
        .trst_n        (trst_n),
        .tdi           (tdi),
        .capture_en    (capture_en),
        .shift_en      (shift_en),
        .update_en     (update_en),
        .extest_en     (extest_en),
        .pin_in        (pin_in),
        .core_pull_low (core_pull_low),
        .tdo           (tdo),
        .pad_pull_low  (pad_pull_low)
    );

    typedef struct {
        int           req;
        bit           is_pad;
        logic [N-1:0] exp;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    initial begin
        tck = 1'b0;
        forever #(TCK_PERIOD/2) tck = ~tck;
    end

    // Reference model of the default map: kinds 0,1,1,2,3 by index mod 5.
    function automatic logic [N-1:0] od_vec();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (i % 5 == 1) || (i % 5 == 2);
        return v;
    endfunction

    function automatic logic [N-1:0] cap_model(logic [N-1:0] pins);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) begin
            if (i % 5 == 3) v[i] = (i == 3) || (i == 13);
            else            v[i] = pins[i];
        end
        return v;
    endfunction

    task automatic tick();
        @(posedge tck);
        #2;
    endtask

    task automatic expect_tdo(int req, logic b);
        item_t it;
        it.req = req; it.is_pad = 1'b0; it.exp = {{(N-1){1'b0}}, b};
        q.push_back(it);
    endtask

    task automatic expect_pad(int req, logic [N-1:0] v);
        item_t it;
        it.req = req; it.is_pad = 1'b1; it.exp = v;
        q.push_back(it);
    endtask

    // Shift N bits; the value on tdo before each edge is the next cell out.
    task automatic shift_vec(logic [N-1:0] din, logic [N-1:0] exp, int req, int fixreq);
        for (int i = 0; i < N; i++) begin
            shift_en = 1'b1;
            tdi      = din[i];
            expect_tdo((i % 5 == 3) ? fixreq : req, exp[i]);
            tick();
        end
        shift_en = 1'b0;
        tdi      = 1'b0;
    endtask

    task automatic capture(logic [N-1:0] pins, logic with_shift);
        pin_in     = pins;
        capture_en = 1'b1;
        shift_en   = with_shift;
        tick();
        capture_en = 1'b0;
        shift_en   = 1'b0;
    endtask

    task automatic update(int req, logic [N-1:0] pad_exp);
        update_en = 1'b1;
        expect_pad(req, pad_exp);
        tick();
        update_en = 1'b0;
    endtask

    // Monitor: compares every queued item shortly after the falling edge.
    initial begin
        forever begin
            @(posedge tck);
            #7;
            while (q.size() > 0) begin
                item_t        it;
                logic [N-1:0] got;
                it  = q.pop_front();
                got = it.is_pad ? pad_pull_low : {{(N-1){1'b0}}, tdo};
                checks++;
                if (got !== it.exp) begin
                    fails++;
                    $display("FAIL R%0d %s got %h expected %h", it.req,
                             it.is_pad ? "pad_pull_low" : "tdo", got, it.exp);
                end
            end
        end
    end

    initial begin
        #(TCK_PERIOD * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired got running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    localparam logic [N-1:0] PAT_A = 20'hA5C3E;
    localparam logic [N-1:0] PAT_B = 20'h3C96B;
    localparam logic [N-1:0] PIN_A = 20'h6B1D4;
    localparam logic [N-1:0] PIN_B = 20'h93E27;

    initial begin
        logic [N-1:0] od;
        od            = od_vec();
        trst_n        = 1'b1;
        tdi           = 1'b0;
        capture_en    = 1'b0;
        shift_en      = 1'b0;
        update_en     = 1'b0;
        extest_en     = 1'b0;
        pin_in        = '0;
        core_pull_low = '0;
        #1 trst_n = 1'b0;
        tick();
        tick();
        trst_n    = 1'b1;
        extest_en = 1'b1;

        // R1: released pads and an all-ones chain after reset
        expect_pad(1, '0);
        tick();
        shift_vec('0, '1, 1, 1);

        // R2: two patterns pushed through the chain in order
        shift_vec(PAT_A, '0, 2, 2);
        shift_vec(PAT_B, PAT_A, 2, 2);

        // R9: pads unchanged after shifting without an update
        expect_pad(9, '0);
        tick();

        // R5: update on the falling edge moves the chain to the pads
        update(5, od & ~PAT_B);

        // R6: all zeros drive every open-drain pad low; R7: nothing else drives
        shift_vec('0, PAT_B, 2, 2);
        update(6, od);
        expect_pad(7, od);
        tick();
        // R6: all ones release them again
        shift_vec('1, '0, 2, 2);
        update(6, '0);

        // R3 and R4: capture two pin patterns
        capture(PIN_A, 1'b0);
        expect_pad(9, '0);   // R9: capture alone does not reach the pads
        shift_vec('0, cap_model(PIN_A), 3, 4);
        capture(PIN_B, 1'b0);
        shift_vec('0, cap_model(PIN_B), 3, 4);

        // R10: capture wins when both strobes are high
        shift_vec(PAT_A, '0, 2, 2);
        capture(~PIN_A, 1'b1);
        shift_vec('0, cap_model(~PIN_A), 10, 10);

        // R8: core path when external test is off
        extest_en     = 1'b0;
        core_pull_low = '1;
        expect_pad(8, od);
        tick();
        core_pull_low = 20'h55555;
        expect_pad(8, od & 20'h55555);
        tick();
        // R7: non open-drain cells stay quiet in core mode too
        core_pull_low = '1;
        expect_pad(7, od);
        tick();
        core_pull_low = '0;

        // R1: reset in the middle of operation releases driven pads
        extest_en = 1'b1;
        update(6, od);       // chain holds zeros from the last read
        trst_n = 1'b0;
        expect_pad(1, '0);
        tick();
        trst_n = 1'b1;
        tick();
        shift_vec('0, '1, 1, 1);

        tick();
        tick();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule